// File: doc/BRIEF.md
# DMA Descriptor Table Controller

This block sequences a single duplex DMA channel on an endpoint. Host software programs the base address of a descriptor table and the number of entries in it, then requests a start. The controller first asks the read engine to copy the whole table into a local FIFO. It then takes the entries out one at a time and hands each one to the read engine or the write engine. It waits for that engine's done pulse before it issues the next entry. Once the FIFO is empty it emits a status word that carries the ID of the last descriptor that completed, plus an error flag. One cycle later it requests an MSI.

Each descriptor is one FIFO word of 93 bits: source address in bits 31:0, destination address in bits 63:32, length in dwords in bits 83:64, ID in bits 91:84 and engine select in bit 92. The read engine delivers each fetched entry as one beat on the table-write port. The data movers themselves lie outside this block.

Top module: `dma_desc_ctrl`

## Requirements
- R1: After reset, every command, status and MSI output is low. The register port decodes three offsets: 0 sets the table address, 1 sets the entry count, and 2 with bit 0 set requests a start.
- R2: A start accepted in idle issues exactly one read-engine command with cmd_fetch=1, cmd_src equal to the table address and cmd_len equal to the entry count times 3 dwords.
- R3: Entries that arrive on the table-write port while the fetch is running are stored in arrival order, up to DEPTH entries. The fetch phase ends on rd_done.
- R4: Entries are dispatched in table order. Engine-select bit 92 set means the write engine and clear means the read engine. cmd_src, cmd_dst and cmd_len are copied from bits 31:0, 63:32 and 83:64, and cmd_fetch is 0.
- R5: Only one entry is in flight at a time. The next entry is issued only after the done input of the engine that took the current one.
- R6: An entry whose length is 0, or greater than 262143 dwords (1,048,572 bytes), is not dispatched and sets the error flag of the run. Lengths of 1 and 262143 are dispatched.
- R7: After the last entry, sts_valid pulses for one cycle with sts_id set to the ID of the last completed descriptor (0 if none completed) and sts_err set to the run's error flag. msi_req then pulses in the following cycle.
- R8: A start request is ignored while a run is in progress. A start request is also ignored when the entry count is 0.
- R9: A count written above DEPTH is held at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| tbl_wr_valid | input | 1 | Fetched table entry valid |
| tbl_wr_data | input | 93 | Fetched table entry |
| rd_done | input | 1 | Read engine finished its command |
| wr_done | input | 1 | Write engine finished its command |
| rd_cmd_valid | output | 1 | Command strobe to the read engine |
| wr_cmd_valid | output | 1 | Command strobe to the write engine |
| cmd_fetch | output | 1 | Command is the table fetch |
| cmd_src | output | 32 | Command source address |
| cmd_dst | output | 32 | Command destination address |
| cmd_len | output | 20 | Command length in dwords |
| sts_valid | output | 1 | Status write strobe |
| sts_id | output | 8 | ID of the last completed descriptor |
| sts_err | output | 1 | A descriptor was skipped in this run |
| msi_req | output | 1 | MSI request |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of a run. The bench models both engines with fixed done latencies. It writes the start register while the first entry is still in flight, then counts fetch commands and MSI pulses once the run has drained. The length limits are reached by placing length 0, 1, 262143 and 262144 entries in one table, which also shows that the reported ID is that of the last entry that actually ran.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DISPATCH,
    ST_WAIT_DONE,
    ST_REPORT
  } ctrl_state_t;
endpackage

// File: rtl/desc_ctrl_regs.sv
module desc_ctrl_regs #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic [CNT_W-1:0]  ent_cnt,
  output logic              start_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_addr  <= '0;
      ent_cnt   <= '0;
      start_req <= 1'b0;
    end else begin
      start_req <= reg_wr && (reg_addr == 2'd2) && reg_wdata[0];
      if (reg_wr && reg_addr == 2'd0)
        tbl_addr <= reg_wdata[ADDR_W-1:0];
      if (reg_wr && reg_addr == 2'd1) begin
        // R9: counts above the FIFO depth are held at the depth
        if (reg_wdata > 32'(DEPTH)) ent_cnt <= CNT_W'(DEPTH);
        else                        ent_cnt <= CNT_W'(reg_wdata);
      end
    end
  end

  assert_cnt_cap_R9: assert property (@(posedge clk) disable iff (rst)
    ent_cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/desc_fifo.sv
module desc_fifo #(
  parameter int W     = 93,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CNT_W-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));

  // storage without reset, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
    if (pop && !empty) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop && !empty) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(push && !full) - CNT_W'(pop && !empty);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/dma_desc_ctrl.sv
module dma_desc_ctrl
  import dma_desc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  parameter int ID_W   = 8,
  parameter int DEPTH  = 16,
  parameter int MAX_DW = 262143,
  localparam int DESC_W  = 2 * ADDR_W + LEN_W + ID_W + 1,
  localparam int DESC_DW = (DESC_W + 31) / 32,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              tbl_wr_valid,
  input  logic [DESC_W-1:0] tbl_wr_data,
  input  logic              rd_done,
  input  logic              wr_done,
  output logic              rd_cmd_valid,
  output logic              wr_cmd_valid,
  output logic              cmd_fetch,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              sts_valid,
  output logic [ID_W-1:0]   sts_id,
  output logic              sts_err,
  output logic              msi_req
);
  localparam int DST_LO = ADDR_W;
  localparam int LEN_LO = 2 * ADDR_W;
  localparam int ID_LO  = LEN_LO + LEN_W;
  localparam int SEL_B  = ID_LO + ID_W;

  ctrl_state_t       state;
  logic [ADDR_W-1:0] tbl_addr;
  logic [CNT_W-1:0]  ent_cnt;
  logic              start_req, start_ok;
  logic [DESC_W-1:0] head;
  logic              fifo_empty, fifo_full, fifo_pop;
  logic              head_pend, rep_phase, run_err, cur_sel;
  logic [ID_W-1:0]   cur_id, last_id;
  logic [LEN_W-1:0]  head_len;
  logic              head_bad;

  desc_ctrl_regs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_regs (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata,
    .tbl_addr, .ent_cnt, .start_req
  );

  // R8: a start counts only in idle with a non-zero entry count
  assign start_ok = start_req && (state == ST_IDLE) && (ent_cnt != '0);
  assign fifo_pop = (state == ST_DISPATCH) && !head_pend && !fifo_empty;

  desc_fifo #(.W(DESC_W), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst,
    .clr  (start_ok),
    .push (tbl_wr_valid && (state == ST_FETCH)),
    .din  (tbl_wr_data),
    .pop  (fifo_pop),
    .dout (head),
    .empty(fifo_empty),
    .full (fifo_full)
  );

  assign head_len = head[ID_LO-1:LEN_LO];
  assign head_bad = (head_len == '0) || (head_len > LEN_W'(MAX_DW));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      rd_cmd_valid <= 1'b0;
      wr_cmd_valid <= 1'b0;
      cmd_fetch    <= 1'b0;
      cmd_src      <= '0;
      cmd_dst      <= '0;
      cmd_len      <= '0;
      sts_valid    <= 1'b0;
      sts_id       <= '0;
      sts_err      <= 1'b0;
      msi_req      <= 1'b0;
      head_pend    <= 1'b0;
      rep_phase    <= 1'b0;
      run_err      <= 1'b0;
      cur_sel      <= 1'b0;
      cur_id       <= '0;
      last_id      <= '0;
    end else begin
      rd_cmd_valid <= 1'b0;
      wr_cmd_valid <= 1'b0;
      sts_valid    <= 1'b0;
      msi_req      <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_ok) begin
          rd_cmd_valid <= 1'b1;
          cmd_fetch    <= 1'b1;
          cmd_src      <= tbl_addr;
          cmd_dst      <= '0;
          cmd_len      <= LEN_W'(ent_cnt * DESC_DW);
          run_err      <= 1'b0;
          last_id      <= '0;
          state        <= ST_FETCH;
        end
        ST_FETCH: if (rd_done) begin
          head_pend <= 1'b0;
          state     <= ST_DISPATCH;
        end
        ST_DISPATCH: begin
          if (head_pend) begin
            head_pend <= 1'b0;
            if (head_bad) begin
              run_err <= 1'b1;
            end else begin
              rd_cmd_valid <= !head[SEL_B];
              wr_cmd_valid <= head[SEL_B];
              cmd_fetch    <= 1'b0;
              cmd_src      <= head[DST_LO-1:0];
              cmd_dst      <= head[LEN_LO-1:DST_LO];
              cmd_len      <= head_len;
              cur_sel      <= head[SEL_B];
              cur_id       <= head[SEL_B-1:ID_LO];
              state        <= ST_WAIT_DONE;
            end
          end else if (fifo_empty) begin
            rep_phase <= 1'b0;
            state     <= ST_REPORT;
          end else begin
            head_pend <= 1'b1;
          end
        end
        ST_WAIT_DONE: if (cur_sel ? wr_done : rd_done) begin
          last_id <= cur_id;
          state   <= ST_DISPATCH;
        end
        ST_REPORT: begin
          if (!rep_phase) begin
            sts_valid <= 1'b1;
            sts_id    <= last_id;
            sts_err   <= run_err;
            rep_phase <= 1'b1;
          end else begin
            msi_req <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_one_engine_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_cmd_valid && wr_cmd_valid));
  assert_len_range_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd_valid || (rd_cmd_valid && !cmd_fetch)) |->
      (cmd_len != '0 && cmd_len <= LEN_W'(MAX_DW)));
  assert_msi_after_sts_R7: assert property (@(posedge clk) disable iff (rst)
    msi_req |-> $past(sts_valid));
  assert_fetch_from_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && $past(state) != ST_FETCH) |-> $past(state) == ST_IDLE);
  assert_fetch_full_R3: assert property (@(posedge clk) disable iff (rst)
    (tbl_wr_valid && state == ST_FETCH) |-> !fifo_full);
endmodule

// File: tb/test_dma_desc_ctrl.sv
module test_dma_desc_ctrl;
  localparam int DW = 93;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          tbl_wr_valid = 1'b0;
  logic [DW-1:0] tbl_wr_data = '0;
  logic          rd_done = 1'b0, wr_done = 1'b0;
  logic          rd_cmd_valid, wr_cmd_valid, cmd_fetch;
  logic [31:0]   cmd_src, cmd_dst;
  logic [19:0]   cmd_len;
  logic          sts_valid, sts_err, msi_req;
  logic [7:0]    sts_id;

  always #2.5 clk = ~clk;

  dma_desc_ctrl i_dma_desc_ctrl (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .tbl_wr_valid, .tbl_wr_data,
    .rd_done, .wr_done, .rd_cmd_valid, .wr_cmd_valid, .cmd_fetch, .cmd_src,
    .cmd_dst, .cmd_len, .sts_valid, .sts_id, .sts_err, .msi_req
  );

  int checks = 0, failures = 0, cyc = 0;
  logic [DW-1:0] tbl [16];
  int rec_n = 0, fetch_n = 0, sts_n = 0, msi_n = 0, overlap = 0;
  int rec_eng [32];
  logic [31:0] rec_src [32], rec_dst [32];
  logic [19:0] rec_len [32];
  logic [31:0] fetch_src;
  logic [19:0] fetch_len;
  logic [7:0]  last_sts_id;
  logic        last_sts_err;
  int sts_cyc = 0, msi_cyc = 0;
  int rd_busy = 0, wr_busy = 0, fetch_left = 0, fetch_idx = 0;
  bit fetching = 0;
  bit done_flag = 0;

  function automatic logic [DW-1:0] mk(bit sel, logic [7:0] id, logic [19:0] len,
                                       logic [31:0] dst, logic [31:0] src);
    return {sel, id, len, dst, src};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // engine models and output monitor
  always @(negedge clk) begin
    cyc++;
    rd_done = 0; wr_done = 0; tbl_wr_valid = 0;
    if (!rst) begin
      if (rd_cmd_valid) begin
        if (cmd_fetch) begin
          fetch_n++; fetch_src = cmd_src; fetch_len = cmd_len;
          fetch_left = cmd_len / 3; fetch_idx = 0; fetching = 1;
        end else begin
          if (rd_busy > 0 || wr_busy > 0) overlap++;
          rec_eng[rec_n] = 0; rec_src[rec_n] = cmd_src; rec_dst[rec_n] = cmd_dst;
          rec_len[rec_n] = cmd_len; rec_n++; rd_busy = 4;
        end
      end
      if (wr_cmd_valid) begin
        if (rd_busy > 0 || wr_busy > 0) overlap++;
        rec_eng[rec_n] = 1; rec_src[rec_n] = cmd_src; rec_dst[rec_n] = cmd_dst;
        rec_len[rec_n] = cmd_len; rec_n++; wr_busy = 6;
      end
      if (sts_valid) begin
        sts_n++; last_sts_id = sts_id; last_sts_err = sts_err; sts_cyc = cyc;
      end
      if (msi_req) begin msi_n++; msi_cyc = cyc; end
      if (fetching) begin
        if (fetch_left > 0) begin
          tbl_wr_valid = 1; tbl_wr_data = tbl[fetch_idx];
          fetch_idx++; fetch_left--;
        end else begin
          rd_done = 1; fetching = 0;
        end
      end else if (rd_busy > 0) begin
        rd_busy--;
        if (rd_busy == 0) rd_done = 1;
      end
      if (wr_busy > 0) begin
        wr_busy--;
        if (wr_busy == 0) wr_done = 1;
      end
    end
  end

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic run_table(logic [31:0] base, int n, string req);
    int m0 = msi_n;
    int t = 0;
    wr_reg(2'd0, base); wr_reg(2'd1, n); wr_reg(2'd2, 32'd1);
    while (msi_n == m0 && t < 3000) begin @(negedge clk); t++; end
    chk(msi_n == m0 + 1, {req, " run completes"}, msi_n - m0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!rd_cmd_valid && !wr_cmd_valid && !sts_valid && !msi_req && !cmd_fetch,
        "R1 reset outputs", {rd_cmd_valid, wr_cmd_valid, sts_valid, msi_req}, 0);
  endtask

  task automatic t_mixed;
    int r0 = rec_n, f0 = fetch_n;
    tbl[0] = mk(0, 8'd5, 20'd16, 32'h2000_0000, 32'h1000_0000);
    tbl[1] = mk(1, 8'd6, 20'd64, 32'h3000_0040, 32'h0000_0100);
    tbl[2] = mk(0, 8'd7, 20'd2,  32'h2000_0100, 32'h1000_0800);
    tbl[3] = mk(1, 8'd9, 20'd8,  32'h3000_1000, 32'h0000_0200);
    run_table(32'h00AB_C000, 4, "R2");
    chk(fetch_n == f0 + 1, "R2 one fetch", fetch_n - f0, 1);
    chk(fetch_src == 32'h00AB_C000, "R2 fetch src", fetch_src, 32'h00AB_C000);
    chk(fetch_len == 20'd12, "R2 fetch len", fetch_len, 12);
    chk(rec_n == r0 + 4, "R3 entries dispatched", rec_n - r0, 4);
    for (int i = 0; i < 4; i++) begin
      chk(rec_eng[r0+i] == int'(tbl[i][92]), "R4 engine select", rec_eng[r0+i], tbl[i][92]);
      chk(rec_src[r0+i] == tbl[i][31:0] && rec_dst[r0+i] == tbl[i][63:32] &&
          rec_len[r0+i] == tbl[i][83:64], "R4 fields", rec_src[r0+i], tbl[i][31:0]);
    end
    chk(overlap == 0, "R5 single outstanding", overlap, 0);
    chk(last_sts_id == 8'd9 && !last_sts_err, "R7 status id", last_sts_id, 9);
    chk(msi_cyc == sts_cyc + 1, "R7 msi one cycle after status", msi_cyc - sts_cyc, 1);
  endtask

  task automatic t_lengths;
    int r0 = rec_n;
    tbl[0] = mk(0, 8'd1, 20'd1,      32'h10, 32'h20);
    tbl[1] = mk(1, 8'd2, 20'd0,      32'h30, 32'h40);
    tbl[2] = mk(1, 8'd3, 20'd262143, 32'h50, 32'h60);
    tbl[3] = mk(0, 8'd4, 20'd262144, 32'h70, 32'h80);
    run_table(32'h4000, 4, "R6");
    chk(rec_n == r0 + 2, "R6 bad lengths skipped", rec_n - r0, 2);
    chk(rec_len[r0] == 20'd1 && rec_len[r0+1] == 20'd262143, "R6 limits accepted",
        rec_len[r0+1], 262143);
    chk(last_sts_err == 1'b1, "R6 error flag", last_sts_err, 1);
    chk(last_sts_id == 8'd3, "R7 last completed id", last_sts_id, 3);
  endtask

  task automatic t_busy_start;
    int f0 = fetch_n, m0 = msi_n, t = 0;
    tbl[0] = mk(1, 8'd11, 20'd4, 32'h1, 32'h2);
    tbl[1] = mk(1, 8'd12, 20'd4, 32'h3, 32'h4);
    wr_reg(2'd0, 32'h8000); wr_reg(2'd1, 2); wr_reg(2'd2, 1);
    repeat (8) @(negedge clk);
    chk(msi_n == m0, "R8 run still busy at second start", msi_n - m0, 0);
    wr_reg(2'd2, 1);
    while (msi_n == m0 && t < 3000) begin @(negedge clk); t++; end
    repeat (30) @(negedge clk);
    chk(fetch_n == f0 + 1, "R8 start while busy ignored", fetch_n - f0, 1);
    chk(msi_n == m0 + 1, "R8 single msi", msi_n - m0, 1);
    chk(last_sts_id == 8'd12, "R7 busy run id", last_sts_id, 12);
  endtask

  task automatic t_zero_count;
    int f0 = fetch_n;
    wr_reg(2'd1, 0); wr_reg(2'd2, 1);
    repeat (30) @(negedge clk);
    chk(fetch_n == f0 && !rd_cmd_valid, "R8 zero count start ignored", fetch_n - f0, 0);
  endtask

  task automatic t_saturate;
    int r0 = rec_n;
    for (int i = 0; i < 16; i++)
      tbl[i] = mk(i[0], 8'(100 + i), 20'(i + 1), 32'(i * 64), 32'(i * 16));
    run_table(32'hC000, 40, "R9");
    chk(fetch_len == 20'd48, "R9 count held at depth", fetch_len, 48);
    chk(rec_n == r0 + 16, "R3 full fifo dispatched", rec_n - r0, 16);
    chk(rec_len[r0+15] == 20'd16, "R3 order kept", rec_len[r0+15], 16);
    chk(last_sts_id == 8'd115, "R7 saturated run id", last_sts_id, 115);
    chk(overlap == 0, "R5 no overlap after all runs", overlap, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst = 0;
    repeat (2) @(negedge clk);
    t_reset;
    t_mixed;
    t_lengths;
    t_busy_start;
    t_zero_count;
    t_saturate;
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(150000 * 5);
    if (!done_flag) begin
      done_flag = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule